// File: doc/BRIEF.md
# Predicated Writeback Nullification Unit

This block sits between the execute stage and the register file of an in-order integer pipeline. Every instruction that leaves execute carries a 6-bit guard selector in the low bits of its instruction word. The block registers the instruction into a writeback slot. In that slot it reads the selected one-bit predicate from a file of 64 predicate registers. If the predicate is false, the instruction still retires in its slot, but its register write or memory write is cancelled. The decision is made only at the writeback gate, so the pipeline never waits for a late condition.

The block keeps the predicate file. A guarded compare writes its outcome to one predicate register and the complement of the outcome to a second predicate register, both in the same cycle. An instruction that reaches writeback in the next cycle already sees both new values. A conditional move-if-zero writes its source value only when its condition operand is zero. In that way the condition becomes a data dependence and not a branch. Predicate 0 always reads true, so instructions that need no guard can name it.

Top module: `pred_wb_gate`

## Requirements
- R1: While reset is held, and in the cycle after release with no instruction presented, retire_valid, retire_nullified, rf_we and mem_we are all 0. After reset, every predicate other than predicate 0 reads false.
- R2: The guard predicate is chosen by ex_instr[5:0]. An ALU operation (ex_op = 2'b00) presented with ex_valid at a clock edge, and whose guard is true, drives rf_we = 1 with rf_waddr = ex_rd and rf_wdata = ex_result in the cycle after that edge.
- R3: An instruction whose guard is false retires with retire_valid = 1 and retire_nullified = 1. It drives rf_we = 0 and mem_we = 0, and it changes no predicate.
- R4: Predicate 0 always reads true, and any compare write aimed at it is ignored. An instruction guarded by predicate 0 is never nullified.
- R5: A compare (ex_op = 2'b10) whose guard is true writes ex_cmp_out into predicate ex_pdst_t and the inverse of ex_cmp_out into predicate ex_pdst_f, in the same cycle. When both targets are the same register, the ex_pdst_t value is the one stored. A compare never asserts rf_we or mem_we.
- R6: A predicate written by a compare that is in writeback in cycle N is the value seen by an instruction that is in writeback in cycle N+1.
- R7: A conditional move-if-zero (ex_op = 2'b11) whose guard is true drives rf_we = 1 with ex_result to ex_rd only when ex_cond is zero. When ex_cond is not zero, rf_we stays 0.
- R8: A store (ex_op = 2'b01) drives mem_we = 1 with mem_wdata = ex_result only when its guard is true. A store never drives rf_we. rf_we and mem_we are never high together.
- R9: The block never stalls. Each cycle in which ex_valid is high is followed by exactly one cycle with retire_valid high. A cycle with ex_valid low is followed by a cycle with retire_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_valid | input | 1 | An instruction is leaving execute |
| ex_instr | input | 32 | Instruction word; bits [5:0] select the guard predicate |
| ex_op | input | 2 | 00 ALU, 01 store, 10 compare, 11 move-if-zero |
| ex_rd | input | 5 | Destination register index |
| ex_result | input | 32 | Result or store data |
| ex_cond | input | 32 | Condition operand of move-if-zero |
| ex_cmp_out | input | 1 | Outcome of a compare |
| ex_pdst_t | input | 6 | Predicate that receives the compare outcome |
| ex_pdst_f | input | 6 | Predicate that receives the inverse of the outcome |
| retire_valid | output | 1 | An instruction retires this cycle |
| retire_nullified | output | 1 | The retiring instruction was cancelled by its guard |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |

## Verification
The assertions check the following relations on every cycle: one retirement per issued instruction, no write enable during a nullified retirement, that a store never writes the register file, that a non-zero move-if-zero never writes, and that predicate 0 never nullifies. Two behaviours need the bench's reference model of the predicate file and cannot be checked cycle by cycle: that compare results and their complements land in the right registers, and that they are visible to the very next instruction. The bench also covers a write aimed at predicate 0 and a compare whose two targets are the same register.

// File: rtl/pred_wb_gate.sv
module pred_wb_gate #(
  parameter int XLEN  = 32,
  parameter int IW    = 32,
  parameter int NPRED = 64,
  parameter int RIDX  = 5,
  localparam int PSEL = $clog2(NPRED)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ex_valid,
  input  logic [IW-1:0]   ex_instr,
  input  logic [1:0]      ex_op,
  input  logic [RIDX-1:0] ex_rd,
  input  logic [XLEN-1:0] ex_result,
  input  logic [XLEN-1:0] ex_cond,
  input  logic            ex_cmp_out,
  input  logic [PSEL-1:0] ex_pdst_t,
  input  logic [PSEL-1:0] ex_pdst_f,
  output logic            retire_valid,
  output logic            retire_nullified,
  output logic            rf_we,
  output logic [RIDX-1:0] rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata
);
  localparam logic [1:0] OP_ALU = 2'b00, OP_ST = 2'b01, OP_CMP = 2'b10, OP_MVZ = 2'b11;

  logic            wb_valid, wb_czero, wb_cmp;
  logic [PSEL-1:0] wb_guard, wb_pt, wb_pf;
  logic [1:0]      wb_op;
  logic [RIDX-1:0] wb_rd;
  logic [XLEN-1:0] wb_result;
  logic [NPRED-1:0] pred_q;
  logic            guard_ok, cmp_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= ex_valid;
    end
    wb_guard  <= ex_instr[PSEL-1:0];
    wb_op     <= ex_op;
    wb_rd     <= ex_rd;
    wb_result <= ex_result;
    wb_czero  <= (ex_cond == '0);
    wb_cmp    <= ex_cmp_out;
    wb_pt     <= ex_pdst_t;
    wb_pf     <= ex_pdst_f;
  end

  assign guard_ok = pred_q[wb_guard];
  assign cmp_fire = wb_valid && guard_ok && (wb_op == OP_CMP);

  always_ff @(posedge clk) begin
    if (!rst_n) pred_q[0] <= 1'b1;
  end

  for (genvar i = 1; i < NPRED; i++) begin : g_pred
    always_ff @(posedge clk) begin
      if (!rst_n)
        pred_q[i] <= 1'b0;
      else if (cmp_fire && wb_pt == PSEL'(i))
        pred_q[i] <= wb_cmp;
      else if (cmp_fire && wb_pf == PSEL'(i))
        pred_q[i] <= ~wb_cmp;
    end
  end

  assign retire_valid     = wb_valid;
  assign retire_nullified = wb_valid && !guard_ok;
  assign rf_we     = wb_valid && guard_ok &&
                     ((wb_op == OP_ALU) || ((wb_op == OP_MVZ) && wb_czero));
  assign rf_waddr  = wb_rd;
  assign rf_wdata  = wb_result;
  assign mem_we    = wb_valid && guard_ok && (wb_op == OP_ST);
  assign mem_wdata = wb_result;
endmodule

module pred_wb_gate_chk #(
  parameter int XLEN  = 32,
  parameter int IW    = 32,
  parameter int NPRED = 64,
  parameter int RIDX  = 5,
  localparam int PSEL = $clog2(NPRED)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ex_valid,
  input logic [IW-1:0]   ex_instr,
  input logic [1:0]      ex_op,
  input logic [XLEN-1:0] ex_cond,
  input logic            retire_valid,
  input logic            retire_nullified,
  input logic            rf_we,
  input logic            mem_we
);
  AST_RETIRE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |=> retire_valid); // R9
  AST_BUBBLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_valid |=> !retire_valid); // R9
  AST_NULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    retire_nullified |-> (!rf_we && !mem_we && retire_valid)); // R3
  AST_P0_NEVER_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_instr[PSEL-1:0] == '0) |=> !retire_nullified); // R4
  AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b01) |=> !rf_we); // R8
  AST_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_we)); // R8
  AST_MVZ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b11 && ex_cond != '0) |=> !rf_we); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_op == 2'b10) |=> (!rf_we && !mem_we)); // R5
endmodule

bind pred_wb_gate pred_wb_gate_chk #(.XLEN(XLEN), .IW(IW), .NPRED(NPRED), .RIDX(RIDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_op(ex_op),
  .ex_cond(ex_cond), .retire_valid(retire_valid), .retire_nullified(retire_nullified),
  .rf_we(rf_we), .mem_we(mem_we));

// File: tb/sim_pred_wb_gate.sv
module sim_pred_wb_gate;
  logic        clk = 0, rst_n = 0;
  logic        ex_valid = 0, ex_cmp_out = 0;
  logic [31:0] ex_instr = 0, ex_result = 0, ex_cond = 0;
  logic [1:0]  ex_op = 0;
  logic [4:0]  ex_rd = 0;
  logic [5:0]  ex_pdst_t = 0, ex_pdst_f = 0;
  logic        retire_valid, retire_nullified, rf_we, mem_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata, mem_wdata;

  int checks = 0, errors = 0;
  logic [63:0] model;
  logic        pend = 0;
  logic [72:0] pend_exp;
  logic        p_upd, p_c;
  logic [5:0]  p_t, p_f;
  string       pend_tag;

  always #5 clk = ~clk;

  pred_wb_gate u0 (.*);

  function automatic logic [72:0] expect_out(logic v, logic [5:0] g, logic [1:0] op,
      logic [4:0] rd, logic [31:0] res, logic [31:0] cond, logic [63:0] m);
    logic ok, we, mw;
    ok = (g == 0) ? 1'b1 : m[g];
    if (!v) return '0;
    we = ok && (op == 2'b00 || (op == 2'b11 && cond == 0));
    mw = ok && (op == 2'b01);
    return {1'b1, !ok, we, we ? rd : 5'd0, we ? res : 32'd0, mw, mw ? res : 32'd0};
  endfunction

  function automatic logic [72:0] actual();
    return {retire_valid, retire_nullified, rf_we, rf_we ? rf_waddr : 5'd0,
            rf_we ? rf_wdata : 32'd0, mem_we, mem_we ? mem_wdata : 32'd0};
  endfunction

  task automatic chk(string tag, logic [72:0] act, logic [72:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    if (pend) begin
      chk(pend_tag, actual(), pend_exp);
      if (p_upd) begin
        if (p_f != 0) model[p_f] = ~p_c;
        if (p_t != 0) model[p_t] = p_c;
      end
    end
    pend = 0;
  endtask

  task automatic issue(string tag, logic v, logic [5:0] g, logic [1:0] op, logic [4:0] rd,
      logic [31:0] res, logic [31:0] cond, logic c, logic [5:0] pt, logic [5:0] pf);
    logic ok;
    @(negedge clk);
    settle();
    ex_valid = v; ex_instr = {$urandom, g} >> 0; ex_instr[5:0] = g; ex_op = op; ex_rd = rd;
    ex_result = res; ex_cond = cond; ex_cmp_out = c; ex_pdst_t = pt; ex_pdst_f = pf;
    ok = (g == 0) ? 1'b1 : model[g];
    pend = 1; pend_tag = tag;
    pend_exp = expect_out(v, g, op, rd, res, cond, model);
    p_upd = v && ok && op == 2'b10; p_c = c; p_t = pt; p_f = pf;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model = 64'd1;
    repeat (3) @(negedge clk);
    chk("R1 reset idle", actual(), '0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 after release", actual(), '0);
    // R1: unwritten predicate guards -> nullified
    issue("R1 p5 false", 1, 6'd5, 2'b00, 5'd3, 32'h11, 0, 0, 0, 0);
    issue("R2 p0 alu", 1, 6'd0, 2'b00, 5'd7, 32'hCAFE, 0, 0, 0, 0);
    // R4: compare aiming false at p0 is ignored
    issue("R4 cmp to p0", 1, 6'd0, 2'b10, 0, 0, 0, 1'b0, 6'd0, 6'd0);
    issue("R4 p0 still true", 1, 6'd0, 2'b00, 5'd1, 32'h44, 0, 0, 0, 0);
    // R5/R6: pair write then immediate use
    issue("R5 cmp pair", 1, 6'd0, 2'b10, 0, 0, 0, 1'b1, 6'd9, 6'd10);
    issue("R6 use p9 next", 1, 6'd9, 2'b00, 5'd2, 32'h99, 0, 0, 0, 0);
    issue("R6 use p10 next", 1, 6'd10, 2'b00, 5'd2, 32'h98, 0, 0, 0, 0);
    // R5: same target, true value wins
    issue("R5 same target", 1, 6'd0, 2'b10, 0, 0, 0, 1'b0, 6'd12, 6'd12);
    issue("R5 same target use", 1, 6'd12, 2'b00, 5'd4, 32'h12, 0, 0, 0, 0);
    // R3: guarded-false compare changes nothing
    issue("R3 null cmp", 1, 6'd12, 2'b10, 0, 0, 0, 1'b1, 6'd9, 6'd10);
    issue("R3 p9 unchanged", 1, 6'd9, 2'b01, 0, 32'h77, 0, 0, 0, 0);
    // R7 / R8 directed
    issue("R7 mvz zero", 1, 6'd0, 2'b11, 5'd5, 32'h55, 32'd0, 0, 0, 0);
    issue("R7 mvz nonzero", 1, 6'd0, 2'b11, 5'd5, 32'h56, 32'd8, 0, 0, 0);
    issue("R8 store false", 1, 6'd10, 2'b01, 0, 32'h66, 0, 0, 0, 0);
    issue("R9 bubble", 0, 6'd0, 2'b00, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      string tag;
      case (op)
        2'b00: tag = "R2 rand alu";
        2'b01: tag = "R8 rand store";
        2'b10: tag = "R5 rand cmp";
        default: tag = "R7 rand mvz";
      endcase
      issue(tag, $urandom_range(0, 7) != 0, 6'($urandom_range(0, 7)), op,
            5'($urandom), $urandom, ($urandom_range(0, 3) == 0) ? 32'd0 : $urandom,
            1'($urandom), 6'($urandom_range(0, 7)), 6'($urandom_range(0, 7)));
    end
    @(negedge clk);
    settle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule